// File: doc/BRIEF.md
# Four-Source Clock Selector with Cascaded Dividers

This block derives one output clock from one of four free-running source clocks. A 32-bit control word holds three fields. The first picks the source. The second is a pre-divider factor, used only when the fourth source is chosen. The third is a small post-divider factor that always applies. The output frequency is the selected source divided by the product of the two factors. Because the block only divides, the output can never run faster than its source.

The block runs in a single system clock domain that is well above the source rates. Each source level passes through a two-flop synchronizer, and the output waveform changes on rising or falling edges of the synchronized selected source. The output is a registered level that trails a source edge by three system cycles. Divider changes take effect only at the start of an output period.

A change of source proceeds in steps. The block first waits for the output to be low. It then holds the output low through a two-cycle gated gap, and only after that does the new source begin driving the output. A partial write uses byte lanes, so software can retune the dividers without disturbing the source selection.

Top module: `muxdiv_clk`

## Requirements
- R1: Bits [17:16] of the control word choose the active source, index 0 to 3, and the output period is then a multiple of that source's period.
- R2: Bits [12:8] hold a pre-divide value P. When source 3 is active, the source is divided by P+1, which ranges from 1 to 32.
- R3: When source 0, 1 or 2 is active, the pre-divide field has no effect on the output, whatever value it holds.
- R4: Bits [5:4] hold a post-divide value D that divides by D+1 (1 to 4). The total ratio N is the product of the pre-divide factor and the post-divide factor.
- R5: The output rises only one system cycle after a synchronized rising edge of the active source, so it never runs faster than that source.
- R6: A write updates only the byte lanes that are enabled. Lane 2 carries the select field, lane 1 the pre-divide field and lane 0 the post-divide field. A field whose lane is not enabled keeps its value.
- R7: When N is 1, the output follows the source. When N is even, the output has a 50% duty cycle. When N is odd, the output is high for ceil(N/2) source periods.
- R8: A new ratio is loaded only at the source rising edge that begins an output period. No period is cut short.
- R9: On a change of source, the block waits until the output is low, keeps it low through a two-cycle gap, and then starts the new source at the beginning of a period.
- R10: After reset the control word reads 0, which means source 0 and divide-by-1. The bits outside the three fields always read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrBe | input | 4 | Byte-lane enables for the write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Control word readback |
| srcLvl | input | 4 | Levels of the four source clocks |
| clkOut | output | 1 | Divided output clock |

## Verification
The sources run at four different periods, so a wrong select shows up as a wrong measured output period. The ratio is tried at 1 on two different sources, which checks the pass-through. It is tried at 9 and 3 on source 3, which checks that the pre-divider and post-divider multiply and that odd ratios get the ceil(N/2) high time. It is tried at 128, the largest ratio, and at 4 on source 1 with a pre-divide value loaded, which shows the bypass. Partial writes that carry conflicting select bits in a disabled lane show whether lane masking holds. A reference model compares the output and the readback on every cycle through each source change and retune, which covers the period-boundary reload and the low gap during a source change.

// File: rtl/muxdiv_clk_pkg.sv
package muxdiv_clk_pkg;
  localparam int NSRC      = 4;
  localparam int SEL_W     = 2;
  localparam int PRE_W     = 5;
  localparam int POST_W    = 2;
  localparam int SEL_LSB   = 16;
  localparam int PRE_LSB   = 8;
  localparam int POST_LSB  = 4;
  localparam int PRE_SRC   = 3;
  localparam int RATIO_W   = PRE_W + POST_W + 1;
  localparam int GAP_CYC   = 2;
  localparam logic [31:0] FIELD_MASK =
    ({{(32-SEL_W){1'b0}}, {SEL_W{1'b1}}} << SEL_LSB) |
    ({{(32-PRE_W){1'b0}}, {PRE_W{1'b1}}} << PRE_LSB) |
    ({{(32-POST_W){1'b0}}, {POST_W{1'b1}}} << POST_LSB);

  typedef struct packed {
    logic               gate;
    logic               restart;
    logic [SEL_W-1:0]   sel;
    logic [RATIO_W-1:0] ratio;
  } strobe_t;
endpackage

// File: rtl/muxdiv_clk_ctrl.sv
module muxdiv_clk_ctrl
  import muxdiv_clk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [3:0]  wrBe,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic        outLvl,
  output strobe_t     stb
);
  localparam int GAP_W = $clog2(GAP_CYC + 1);

  logic [SEL_W-1:0]  selR, activeSel;
  logic [PRE_W-1:0]  preR;
  logic [POST_W-1:0] postR;
  logic              inGap;
  logic [GAP_W-1:0]  gapCnt;
  logic              wantSwap;
  logic [RATIO_W-1:0] preF, postF;
  logic              unusedWr;

  assign unusedWr = ^{wrBe[3], wrData[31:SEL_LSB+SEL_W], wrData[SEL_LSB-1:PRE_LSB+PRE_W],
                      wrData[PRE_LSB-1:POST_LSB+POST_W], wrData[POST_LSB-1:0]};

  // register with byte-lane enables
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selR  <= '0;
      preR  <= '0;
      postR <= '0;
    end else if (wrEn) begin
      if (wrBe[SEL_LSB/8])  selR  <= wrData[SEL_LSB +: SEL_W];
      if (wrBe[PRE_LSB/8])  preR  <= wrData[PRE_LSB +: PRE_W];
      if (wrBe[POST_LSB/8]) postR <= wrData[POST_LSB +: POST_W];
    end
  end

  always_comb begin
    rdData = '0;
    rdData[SEL_LSB +: SEL_W]   = selR;
    rdData[PRE_LSB +: PRE_W]   = preR;
    rdData[POST_LSB +: POST_W] = postR;
  end

  // source handover
  assign wantSwap = (selR != activeSel) && !outLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeSel <= '0;
      inGap     <= 1'b0;
      gapCnt    <= '0;
    end else if (!inGap) begin
      if (wantSwap) begin
        inGap  <= 1'b1;
        gapCnt <= '0;
      end
    end else if (gapCnt == GAP_W'(GAP_CYC - 1)) begin
      inGap     <= 1'b0;
      activeSel <= selR;
    end else begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  assign preF  = (activeSel == SEL_W'(PRE_SRC)) ? RATIO_W'(preR) + 1'b1 : RATIO_W'(1);
  assign postF = RATIO_W'(postR) + 1'b1;

  always_comb begin
    stb.gate    = inGap || wantSwap;
    stb.restart = inGap && (gapCnt == GAP_W'(GAP_CYC - 1));
    stb.sel     = activeSel;
    stb.ratio   = RATIO_W'(preF * postF);
  end
endmodule

// File: rtl/muxdiv_clk_path.sv
module muxdiv_clk_path
  import muxdiv_clk_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] srcLvl,
  input  strobe_t         stb,
  output logic [NSRC-1:0] srcRise,
  output logic            clkOut
);
  logic [NSRC-1:0]    syncA, syncB, prevB, srcFall;
  logic [RATIO_W-1:0] cnt, nAct;
  logic [RATIO_W:0]   hiLen, nxtCnt;

  for (genvar g = 0; g < NSRC; g++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA[g] <= 1'b0;
        syncB[g] <= 1'b0;
        prevB[g] <= 1'b0;
      end else begin
        syncA[g] <= srcLvl[g];
        syncB[g] <= syncA[g];
        prevB[g] <= syncB[g];
      end
    end
    assign srcRise[g] = syncB[g] & ~prevB[g];
    assign srcFall[g] = ~syncB[g] & prevB[g];
  end

  assign hiLen  = ({1'b0, nAct} + 1'b1) >> 1;
  assign nxtCnt = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      nAct   <= RATIO_W'(1);
      clkOut <= 1'b0;
    end else if (stb.restart) begin
      cnt    <= '0;
      nAct   <= RATIO_W'(1);
      clkOut <= 1'b0;
    end else if (!stb.gate) begin
      if (srcRise[stb.sel]) begin
        if (nxtCnt == {1'b0, nAct}) begin
          cnt    <= '0;
          nAct   <= stb.ratio;
          clkOut <= 1'b1;
        end else begin
          cnt    <= nxtCnt[RATIO_W-1:0];
          clkOut <= (nxtCnt < hiLen);
        end
      end else if (srcFall[stb.sel] && nAct == RATIO_W'(1)) begin
        clkOut <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/muxdiv_clk.sv
module muxdiv_clk
  import muxdiv_clk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [3:0]  wrBe,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic [3:0]  srcLvl,
  output logic        clkOut
);
  strobe_t         stb;
  logic [NSRC-1:0] srcRise;

  muxdiv_clk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBe(wrBe), .wrData(wrData),
    .rdData(rdData), .outLvl(clkOut), .stb(stb)
  );

  muxdiv_clk_path u_path (
    .clk(clk), .rstN(rstN), .srcLvl(srcLvl), .stb(stb),
    .srcRise(srcRise), .clkOut(clkOut)
  );
endmodule

// File: rtl/muxdiv_clk_chk.sv
module muxdiv_clk_chk
  import muxdiv_clk_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            wrEn,
  input logic [3:0]      wrBe,
  input logic [31:0]     rdData,
  input logic            clkOut,
  input strobe_t         stb,
  input logic [NSRC-1:0] srcRise
);
  p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & ~FIELD_MASK) == 32'h0);

  p_sel_kept_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrBe[SEL_LSB/8]) |=> $stable(rdData[SEL_LSB +: SEL_W]));

  p_gated_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.gate |-> !clkOut);

  p_restart_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.restart |=> !clkOut);

  p_rise_on_edge_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkOut) |-> $past(srcRise[stb.sel]));
endmodule

bind muxdiv_clk muxdiv_clk_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBe(wrBe), .rdData(rdData),
  .clkOut(clkOut), .stb(stb), .srcRise(srcRise)
);

// File: tb/sim_muxdiv_clk.sv
`timescale 1ns/1ps
module sim_muxdiv_clk;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrBe = 4'h0;
  logic [31:0] wrData = 32'h0;
  logic [31:0] rdData;
  logic [3:0]  srcLvl = 4'h0;
  logic        clkOut;

  int checks = 0, errors = 0, cyc = 0;

  muxdiv_clk u0 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBe(wrBe), .wrData(wrData),
                 .rdData(rdData), .srcLvl(srcLvl), .clkOut(clkOut));

  always #10 clk = ~clk;

  // free-running sources, half periods in system cycles
  int halfP [4] = '{3, 4, 5, 2};
  int srcCnt [4] = '{0, 0, 0, 0};
  always @(negedge clk) begin
    cyc++;
    for (int i = 0; i < 4; i++) begin
      srcCnt[i]++;
      if (srcCnt[i] >= halfP[i]) begin
        srcCnt[i] = 0;
        srcLvl[i] <= ~srcLvl[i];
      end
    end
  end

  // behavioural reference model
  int d1 [4], d2 [4], pv [4];
  int mSel, mPre, mPost, mAct, mGap, mGapCnt, mCnt, mN, mOut;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) begin d1[i] = 0; d2[i] = 0; pv[i] = 0; end
      mSel = 0; mPre = 0; mPost = 0; mAct = 0; mGap = 0; mGapCnt = 0;
      mCnt = 0; mN = 1; mOut = 0;
    end else begin
      int oldOut, gate, restart, ratio, rise, fall;
      oldOut  = mOut;
      gate    = (mGap != 0) || (mSel != mAct && oldOut == 0);
      restart = (mGap != 0) && (mGapCnt == 1);
      ratio   = ((mAct == 3) ? mPre + 1 : 1) * (mPost + 1);
      rise    = (d2[mAct] == 1 && pv[mAct] == 0);
      fall    = (d2[mAct] == 0 && pv[mAct] == 1);
      if (restart) begin
        mCnt = 0; mN = 1; mOut = 0;
      end else if (!gate) begin
        if (rise) begin
          if (mCnt + 1 == mN) begin mCnt = 0; mN = ratio; mOut = 1; end
          else begin mCnt++; mOut = (mCnt < (mN + 1) / 2) ? 1 : 0; end
        end else if (fall && mN == 1) mOut = 0;
      end
      if (mGap == 0) begin
        if (mSel != mAct && oldOut == 0) begin mGap = 1; mGapCnt = 0; end
      end else if (mGapCnt == 1) begin
        mGap = 0; mAct = mSel;
      end else mGapCnt++;
      if (wrEn) begin
        if (wrBe[2]) mSel  = int'(wrData[17:16]);
        if (wrBe[1]) mPre  = int'(wrData[12:8]);
        if (wrBe[0]) mPost = int'(wrData[5:4]);
      end
      for (int i = 0; i < 4; i++) begin pv[i] = d2[i]; d2[i] = d1[i]; d1[i] = int'(srcLvl[i]); end
    end
  end

  // every-cycle comparison (R5 R7 R8 R9 waveform, R10 readback)
  always @(negedge clk) begin
    if (rstN) begin
      logic [31:0] expRd;
      expRd = (32'(mSel) << 16) | (32'(mPre) << 8) | (32'(mPost) << 4);
      checks++;
      if (clkOut !== mOut[0]) begin
        errors++;
        $display("FAIL R5/R7/R8/R9 cycle %0d clkOut=%0b expected %0d", cyc, clkOut, mOut);
      end
      checks++;
      if (rdData !== expRd) begin
        errors++;
        $display("FAIL R6/R10 cycle %0d rdData=%h expected %h", cyc, rdData, expRd);
      end
    end
  end

  // period and high-time monitor
  int lastRise = 0, perLast = 0, hiLast = 0, riseCnt = 0;
  logic prevOut = 1'b0;
  always @(negedge clk) begin
    if (clkOut && !prevOut) begin perLast = cyc - lastRise; lastRise = cyc; riseCnt++; end
    if (!clkOut && prevOut) hiLast = cyc - lastRise;
    prevOut = clkOut;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrBe = be; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrBe = 4'h0; wrData = 32'h0;
  endtask

  task automatic measure(input string tag, input int expPer, input int expHi);
    int start;
    start = riseCnt;
    while (riseCnt < start + 3) @(negedge clk);
    @(negedge clk);
    while (clkOut) @(negedge clk);
    @(negedge clk);
    check({tag, " period"}, perLast, expPer);
    check({tag, " high"}, hiLast, expHi);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset readback", int'(rdData), 0);
    check("R10 reset output", int'(clkOut), 0);
    rstN = 1'b1;
    // R1 R7: source 0 pass-through, period 6
    measure("R1 R7 src0 N=1", 6, 3);
    // R2 R4 R7 R10: source 3, pre=2 post=2 -> N=9, junk bits ignored
    wr(4'hF, 32'hC003_E22F);
    check("R10 unused bits", int'(rdData), 32'h0003_0220);
    measure("R2 R4 R7 src3 N=9", 36, 20);
    // R6: lanes 0-1 only, select bits in data are ignored -> N=128
    wr(4'h3, 32'h0001_1F30);
    check("R6 select kept", int'(rdData), 32'h0003_1F30);
    measure("R2 R4 R7 src3 N=128", 512, 256);
    // R3 R6: lane 2 only, source 1, pre ignored -> N=4
    wr(4'h4, 32'h0001_0000);
    check("R6 dividers kept", int'(rdData), 32'h0001_1F30);
    measure("R3 R9 src1 N=4", 32, 16);
    // R1 R3: source 2 with pre loaded, post 0 -> N=1
    wr(4'h7, 32'h0002_0500);
    measure("R1 R3 src2 N=1", 10, 5);
    // R7 odd ratio: source 3, pre=0 post=2 -> N=3
    wr(4'h7, 32'h0003_0020);
    measure("R7 src3 N=3", 12, 8);
    // R8: retune mid-period, post=1 -> N=2
    repeat (5) @(negedge clk);
    wr(4'h1, 32'h0000_0010);
    measure("R8 src3 N=2", 8, 4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule